// File: doc/BRIEF.md
# Serial Configuration Port for a Fractional-N Synthesizer Controller

This block receives write-only configuration frames over a three-wire serial link (serial clock, serial data, load strobe) and turns them into the static settings used by a fractional-N frequency synthesizer controller. The three serial wires are asynchronous to the block. Each wire passes through a two-flop synchronizer, and all edges are detected in the system clock domain.

A frame carries a 20-bit data word followed by a 4-bit register address. A rising edge on the load strobe decodes the address and updates one of four setting groups:

- the fractional numerator;
- the integer divide value together with the normal charge-pump current;
- the divider and lock-detect control group;
- the fast-lock control group.

A numerator write is held in a shadow copy. It reaches the active numerator output only when the integer group is written, so both parts of a new frequency take effect in the same cycle. Each numerator or integer write raises a one-cycle frequency-change strobe, which downstream logic uses to restart its fast-lock timer.

Top module: `synth_cfg_port`

## Requirements
- R1: After reset every setting output is zero and the frequency-change strobe is low.
- R2: A bit is taken on each synchronized rising edge of the serial clock while the load strobe is low. Serial clock edges seen while the load strobe is high shift nothing. A frame is 20 data bits, most significant first (D19 first), followed by 4 address bits, most significant first.
- R3: When more than 24 bits arrive before the load strobe rises, only the last 24 bits shifted in form the frame.
- R4: Each rising edge of the load strobe applies the captured frame exactly once. A setting group changes only after a frame addressed to it.
- R5: A frame with address 1 stores D17..D0 as the 18-bit two's-complement numerator in a shadow copy. D19..D18 are discarded. The active numerator output does not change.
- R6: A frame with address 2 loads the charge-pump current code from D18..D15 and the integer value from D14..D0. In the same cycle, the active numerator takes the shadow value.
- R7: A frame with address 3 loads the divider group with these fields: charge-pump tri-state (D15), dither enable (D14), lock window select (D13..D12), analog lock-detect select (D11), charge-pump polarity invert (D10), prescaler select (D9..D8), and reference divide ratio (D7..D0).
- R8: A frame with address 4 loads the fast-lock group with these fields: fast-lock enable (D16), fast-lock pump current (D15..D13), and fast-lock period count (D12..D0).
- R9: Each frame with address 1 or address 2 produces exactly one frequency-change strobe, lasting one system clock cycle. Frames with any other address produce no strobe.
- R10: A frame whose address is 0 or 5 to 15 changes no setting output and leaves the shadow numerator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_data_i | input | 1 | Serial data, asynchronous |
| ser_le_i | input | 1 | Load strobe, asynchronous |
| num_o | output | 18 | Active fractional numerator |
| int_o | output | 15 | Integer divide value |
| cp_norm_o | output | 4 | Normal charge-pump current code |
| cp_tristate_o | output | 1 | Charge-pump tri-state request |
| dither_o | output | 1 | Modulator dither enable |
| ld_window_o | output | 2 | Lock-detect phase window select |
| ld_analog_o | output | 1 | Analog lock-detect select |
| cp_invert_o | output | 1 | Charge-pump polarity invert |
| presc_o | output | 2 | Prescaler select |
| ref_div_o | output | 8 | Reference divide ratio |
| fast_en_o | output | 1 | Fast-lock enable |
| cp_fast_o | output | 3 | Fast-lock charge-pump current code |
| fast_count_o | output | 13 | Fast-lock period count |
| freq_chg_o | output | 1 | One-cycle frequency-change strobe |

## Verification
The assertions check the following on every cycle:

- the active numerator moves only in the cycle after an integer write;
- a numerator-only write leaves the active numerator alone;
- a frame with an unknown address leaves every group stable;
- serial clock edges seen with the load strobe high never move the shift register;
- the strobe never lasts two cycles.

Only the bench scenarios can show the rest: that field positions land correctly, that an overlong burst keeps only its last 24 bits, that a later numerator write overrides an earlier one before the integer commit, and that strobes are counted once per numerator or integer frame.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

  localparam int DATA_W  = 20;
  localparam int ADDR_W  = 4;
  localparam int FRAME_W = DATA_W + ADDR_W;
  localparam int NUM_W   = 18;
  localparam int INT_W   = 15;
  localparam int CP1_W   = 4;
  localparam int RDIV_W  = 8;
  localparam int FAST_W  = 13;
  localparam int CP2_W   = 3;
  localparam int N_GROUPS = 4;

  typedef enum logic [ADDR_W-1:0] {
    ADR_NUM  = 4'd1,
    ADR_INT  = 4'd2,
    ADR_DIV  = 4'd3,
    ADR_FAST = 4'd4
  } cfg_addr_e;

  typedef struct packed {
    logic              tristate;
    logic              dither;
    logic [1:0]        ld_win;
    logic              ld_analog;
    logic              cp_inv;
    logic [1:0]        presc;
    logic [RDIV_W-1:0] ref_div;
  } div_cfg_t;

  typedef struct packed {
    logic              en;
    logic [CP2_W-1:0]  cp;
    logic [FAST_W-1:0] count;
  } fast_cfg_t;

  localparam int DIV_CFG_W  = $bits(div_cfg_t);
  localparam int FAST_CFG_W = $bits(fast_cfg_t);

  function automatic logic [DATA_W-1:0] frame_data(input logic [FRAME_W-1:0] f);
    return f[FRAME_W-1:ADDR_W];
  endfunction

  function automatic logic [ADDR_W-1:0] frame_addr(input logic [FRAME_W-1:0] f);
    return f[ADDR_W-1:0];
  endfunction

  function automatic logic [NUM_W-1:0] get_num(input logic [DATA_W-1:0] d);
    return d[NUM_W-1:0];
  endfunction

  function automatic logic [INT_W-1:0] get_int(input logic [DATA_W-1:0] d);
    return d[INT_W-1:0];
  endfunction

  function automatic logic [CP1_W-1:0] get_cp1(input logic [DATA_W-1:0] d);
    return d[INT_W+CP1_W-1:INT_W];
  endfunction

  function automatic div_cfg_t get_div(input logic [DATA_W-1:0] d);
    return div_cfg_t'(d[DIV_CFG_W-1:0]);
  endfunction

  function automatic fast_cfg_t get_fast(input logic [DATA_W-1:0] d);
    return fast_cfg_t'(d[FAST_CFG_W-1:0]);
  endfunction

endpackage

// File: rtl/synth_cfg_sync.sv
module synth_cfg_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] level_o
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign level_o = stage_q[STAGES-1];

endmodule

// File: rtl/synth_cfg_shifter.sv
module synth_cfg_shifter
  import synth_cfg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_lvl_i,
  input  logic               sdata_lvl_i,
  input  logic               le_lvl_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               load_o
);

  logic               sclk_prev_q, le_prev_q;
  logic               sclk_rise, le_rise, shift_en;
  logic [FRAME_W-1:0] sr_q, cap_q;
  logic               load_q;

  assign sclk_rise = sclk_lvl_i & ~sclk_prev_q;
  assign le_rise   = le_lvl_i & ~le_prev_q;
  assign shift_en  = sclk_rise & ~le_lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q <= 1'b0;
      le_prev_q   <= 1'b0;
      sr_q        <= '0;
      cap_q       <= '0;
      load_q      <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_lvl_i;
      le_prev_q   <= le_lvl_i;
      if (shift_en) sr_q <= {sr_q[FRAME_W-2:0], sdata_lvl_i};
      if (le_rise)  cap_q <= sr_q;
      load_q <= le_rise;
    end
  end

  assign frame_o = cap_q;
  assign load_o  = load_q;

  // R2: clock edges while the load strobe is high leave the shift register alone
  assert_no_shift_le_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_rise && le_lvl_i) |=> $stable(sr_q));

  // R4: one apply per load-strobe rise
  assert_single_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_q |=> !load_q);

endmodule

// File: rtl/synth_cfg_regs.sv
module synth_cfg_regs
  import synth_cfg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [NUM_W-1:0]   num_o,
  output logic [INT_W-1:0]   int_o,
  output logic [CP1_W-1:0]   cp1_o,
  output div_cfg_t           div_o,
  output fast_cfg_t          fast_o,
  output logic               freq_chg_o
);

  logic [DATA_W-1:0]   data;
  logic [ADDR_W-1:0]   addr;
  logic [N_GROUPS-1:0] wr_sel;
  logic                wr_num, wr_int, wr_div, wr_fast, addr_bad;
  logic                unused_bits;

  assign data        = frame_data(frame_i);
  assign addr        = frame_addr(frame_i);
  assign unused_bits = data[DATA_W-1];

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_dec
    assign wr_sel[g] = load_i && (addr == ADDR_W'(g + 1));
  end

  assign wr_num   = wr_sel[ADR_NUM - 1];
  assign wr_int   = wr_sel[ADR_INT - 1];
  assign wr_div   = wr_sel[ADR_DIV - 1];
  assign wr_fast  = wr_sel[ADR_FAST - 1];
  assign addr_bad = load_i && (wr_sel == '0);

  logic [NUM_W-1:0] num_sh_q, num_q;
  logic [INT_W-1:0] int_q;
  logic [CP1_W-1:0] cp1_q;
  div_cfg_t         div_q;
  fast_cfg_t        fast_q;
  logic             strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      num_sh_q <= '0;
      num_q    <= '0;
      int_q    <= '0;
      cp1_q    <= '0;
      div_q    <= '0;
      fast_q   <= '0;
      strobe_q <= 1'b0;
    end else begin
      if (wr_num) num_sh_q <= get_num(data);
      if (wr_int) begin
        num_q <= num_sh_q;
        int_q <= get_int(data);
        cp1_q <= get_cp1(data);
      end
      if (wr_div)  div_q  <= get_div(data);
      if (wr_fast) fast_q <= get_fast(data);
      strobe_q <= wr_num | wr_int;
    end
  end

  assign num_o      = num_q;
  assign int_o      = int_q;
  assign cp1_o      = cp1_q;
  assign div_o      = div_q;
  assign fast_o     = fast_q;
  assign freq_chg_o = strobe_q;

  // R6: the active numerator moves only as part of an integer commit
  assert_num_commit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (num_q != $past(num_q)) |-> $past(wr_int));

  // R5: a numerator-only frame leaves the active numerator in place
  assert_shadow_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_num |=> $stable(num_q));

  // R4: the divider group changes only after a frame addressed to it
  assert_div_owner_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q != $past(div_q)) |-> $past(wr_div));

  // R10: an unknown address touches nothing
  assert_bad_addr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_bad |=> ($stable(num_sh_q) && $stable(num_q) && $stable(int_q) &&
                  $stable(cp1_q) && $stable(div_q) && $stable(fast_q) && !strobe_q));

  // R9: the strobe lasts a single cycle
  assert_strobe_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_q |=> !strobe_q);

endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port
  import synth_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_clk_i,
  input  logic              ser_data_i,
  input  logic              ser_le_i,
  output logic [NUM_W-1:0]  num_o,
  output logic [INT_W-1:0]  int_o,
  output logic [CP1_W-1:0]  cp_norm_o,
  output logic              cp_tristate_o,
  output logic              dither_o,
  output logic [1:0]        ld_window_o,
  output logic              ld_analog_o,
  output logic              cp_invert_o,
  output logic [1:0]        presc_o,
  output logic [RDIV_W-1:0] ref_div_o,
  output logic              fast_en_o,
  output logic [CP2_W-1:0]  cp_fast_o,
  output logic [FAST_W-1:0] fast_count_o,
  output logic              freq_chg_o
);

  localparam int N_SYNC = 3;

  logic [N_SYNC-1:0]  lvl;
  logic [FRAME_W-1:0] frame;
  logic               load;
  div_cfg_t           div_cfg;
  fast_cfg_t          fast_cfg;

  synth_cfg_sync #(.W(N_SYNC), .STAGES(2)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({ser_le_i, ser_data_i, ser_clk_i}),
    .level_o (lvl)
  );

  synth_cfg_shifter u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_lvl_i  (lvl[0]),
    .sdata_lvl_i (lvl[1]),
    .le_lvl_i    (lvl[2]),
    .frame_o     (frame),
    .load_o      (load)
  );

  synth_cfg_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .frame_i    (frame),
    .num_o      (num_o),
    .int_o      (int_o),
    .cp1_o      (cp_norm_o),
    .div_o      (div_cfg),
    .fast_o     (fast_cfg),
    .freq_chg_o (freq_chg_o)
  );

  assign cp_tristate_o = div_cfg.tristate;
  assign dither_o      = div_cfg.dither;
  assign ld_window_o   = div_cfg.ld_win;
  assign ld_analog_o   = div_cfg.ld_analog;
  assign cp_invert_o   = div_cfg.cp_inv;
  assign presc_o       = div_cfg.presc;
  assign ref_div_o     = div_cfg.ref_div;
  assign fast_en_o     = fast_cfg.en;
  assign cp_fast_o     = fast_cfg.cp;
  assign fast_count_o  = fast_cfg.count;

endmodule

// File: tb/synth_cfg_port_bench.sv
module synth_cfg_port_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, sle = 1'b0;
  logic [17:0] num;
  logic [14:0] intv;
  logic [3:0]  cpn;
  logic        tri_s, dith, lda, cpi, fen, stb;
  logic [1:0]  ldw, pre;
  logic [7:0]  rdiv;
  logic [2:0]  cpf;
  logic [12:0] fcnt;

  always #5 clk = ~clk;

  synth_cfg_port u_synth_cfg_port (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(sclk), .ser_data_i(sdata), .ser_le_i(sle),
    .num_o(num), .int_o(intv), .cp_norm_o(cpn), .cp_tristate_o(tri_s), .dither_o(dith),
    .ld_window_o(ldw), .ld_analog_o(lda), .cp_invert_o(cpi), .presc_o(pre),
    .ref_div_o(rdiv), .fast_en_o(fen), .cp_fast_o(cpf), .fast_count_o(fcnt),
    .freq_chg_o(stb)
  );

  typedef struct {
    string       tag;
    logic [17:0] num;
    logic [14:0] intv;
    logic [3:0]  cp1;
    logic [15:0] divg;
    logic [16:0] fastg;
    int          strobes;
  } exp_t;

  exp_t q[$];
  event chk_ev;
  int checks = 0, errors = 0, strobe_seen = 0, wide_strobe = 0;
  bit finished = 0;
  logic [17:0] m_shadow = '0;
  exp_t model = '{tag: "", num: '0, intv: '0, cp1: '0, divg: '0, fastg: '0, strobes: 0};

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // strobe monitor
  logic prev_stb = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stb) strobe_seen++;
      if (stb && prev_stb) wide_strobe++;
      prev_stb = stb;
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "num", 32'(num), 32'(e.num));
        chk(e.tag, "int", 32'(intv), 32'(e.intv));
        chk(e.tag, "cp_norm", 32'(cpn), 32'(e.cp1));
        chk(e.tag, "div group", 32'({tri_s, dith, ldw, lda, cpi, pre, rdiv}), 32'(e.divg));
        chk(e.tag, "fast group", 32'({fen, cpf, fcnt}), 32'(e.fastg));
        chk(e.tag, "strobe count", 32'(strobe_seen), 32'(e.strobes));
      end
    end
  end

  task automatic push_expect(input string tag);
    exp_t e;
    e = model;
    e.tag = tag;
    q.push_back(e);
    ->chk_ev;
    @(negedge clk);
  endtask

  // bench model of R5..R10, written from the field lists
  task automatic model_apply(input logic [19:0] d, input logic [3:0] a);
    case (a)
      4'd1: begin m_shadow = d[17:0]; model.strobes++; end
      4'd2: begin model.num = m_shadow; model.intv = d[14:0]; model.cp1 = d[18:15]; model.strobes++; end
      4'd3: model.divg = d[15:0];
      4'd4: model.fastg = d[16:0];
      default: ;
    endcase
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); sdata = b;
    repeat (3) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_le();
    repeat (2) @(negedge clk);
    sle = 1'b1;
    repeat (6) @(negedge clk);
    sle = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic write_frame(input string tag, input logic [19:0] d, input logic [3:0] a);
    logic [23:0] f;
    f = {d, a};
    for (int i = 23; i >= 0; i--) send_bit(f[i]);
    pulse_le();
    model_apply(d, a);
    push_expect(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    push_expect("R1 reset");

    write_frame("R7 divider group", 20'h0_C9A5, 4'd3);
    write_frame("R8 fast group", 20'h1_6ABC, 4'd4);
    write_frame("R5 shadow only", 20'h3_2666, 4'd1);
    write_frame("R6 integer commit", 20'h4_01D1, 4'd2);
    write_frame("R6 integer again", 20'hF_7FFF, 4'd2);
    write_frame("R5 upper bits dropped", 20'hF_3333, 4'd1);
    write_frame("R5 second shadow wins", 20'h2_3333, 4'd1);
    write_frame("R6 commit negative", 20'h0_01D5, 4'd2);
    write_frame("R10 address 0", 20'hF_FFFF, 4'd0);
    write_frame("R10 address 9", 20'hF_FFFF, 4'd9);
    write_frame("R10 address 15", 20'hA_5A5A, 4'd15);

    // R3: three leading junk bits, only the last 24 form the frame
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    write_frame("R3 overlong burst", 20'h0_3F04, 4'd3);

    // R2: clock edges while the load strobe is high must not shift
    begin
      logic [23:0] f;
      f = {20'h0_5A81, 4'd3};
      for (int i = 23; i >= 0; i--) send_bit(f[i]);
      @(negedge clk); sle = 1'b1;
      repeat (8) @(negedge clk);
      for (int k = 0; k < 3; k++) send_bit(1'b1);
      sle = 1'b0;
      repeat (4) @(negedge clk);
      pulse_le();
      model_apply(20'h0_5A81, 4'd3);
      push_expect("R2 edges with load high ignored");
    end

    write_frame("R9 fast write no strobe", 20'h0_0001, 4'd4);
    chk("R9", "strobe width violations", 32'(wide_strobe), 32'd0);
    summary();
  end

endmodule